// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block gathers interrupt requests from eight peripheral lines and presents a single interrupt line to a processor. A request is captured on the rising edge of its line and held until the processor takes it. A software-written mask hides chosen levels. Among the remaining requests, the block picks the one with the strongest priority. A request is taken only if it outranks every level that is already being serviced, so a handler can be interrupted by a more urgent level.

The processor answers with two acknowledge strobes. The first strobe moves the winning level from pending to in-service. The second strobe presents an 8-bit type code on the data pins. The upper five bits of that code are a programmable base and the lower three bits are the level number. A small write port sets the mask and the base, and it accepts an end-of-service command. That command retires the most urgent level in service.

Top module: `prio_intc`

## Requirements
- R1: A rising edge on `irq_in[k]` latches request k. A line that simply stays high after its request was taken latches nothing new.
- R2: Setting mask bit k (write to address 0) keeps a latched request k from raising `int_out`. Clearing the bit later lets it through.
- R3: `int_out` is high exactly when some latched, unmasked request outranks every level in service.
- R4: Level 0 has the highest priority and level 7 the lowest. The type code always reports the best eligible level.
- R5: The first `ack` strobe marks the winning level in service and drops its pending request. If nothing else is eligible, `int_out` falls in the following cycle.
- R6: During the second `ack` strobe, `data_out` = {base[4:0], level[2:0]}. The base is written through address 1 from bits 7:3 of `cfg_wdata`.
- R7: While level k is in service, requests at levels k..7 are held off, and requests at levels below k are still signalled.
- R8: A write to address 2 clears the in-service bit of the most urgent level in service.
- R9: `data_oe` is high only during the second `ack` strobe. At all other times it is low and `data_out` is zero.
- R10: A new rising edge on a level in the same cycle as the first strobe that takes that level leaves a fresh request pending.
- R11: A first strobe with no eligible request reports level 7 and changes no in-service bit.
- R12: Reset clears the pending, in-service and mask registers, the base and the strobe phase. `int_out` and `data_oe` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Peripheral request lines, rising-edge sensitive |
| ack | input | 1 | Acknowledge strobe, one cycle; alternates first/second |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | 0 mask, 1 type base, 2 end-of-service |
| cfg_wdata | input | 8 | Configuration write data |
| int_out | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Type code, valid in the second strobe |
| data_oe | output | 1 | Drive enable for the data pins |

## Verification
Two functions can fall on the same level in one cycle: the first acknowledge strobe clears the pending bit of level 2, and a new rising edge on line 2 sets it again. The bench raises line 2, drops it, and then raises it again in the very cycle that `ack` is high. It then expects `int_out` to stay low while level 2 is in service. After an end-of-service write, it expects `int_out` to rise and a second grant to report level 2. This shows that the set took precedence over the clear.

// File: rtl/intc_pkg.sv
package intc_pkg;
   typedef enum logic [1:0] {
      CFG_MASK = 2'd0,
      CFG_BASE = 2'd1,
      CFG_EOI  = 2'd2
   } cfg_addr_e;
endpackage

// File: rtl/intc_first_set.sv
module intc_first_set #(
   parameter int N = 8,
   localparam int W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0] vec,
   output logic         found,
   output logic [W-1:0] idx,
   output logic [N-1:0] onehot
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = W'(i);
         end
      end
      onehot = found ? (N'(1) << idx) : '0;
   end
endmodule

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq,
   input  logic [N-1:0] clr,
   output logic [N-1:0] pend
);
   logic [N-1:0] irq_prev;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_prev <= '0;
      else        irq_prev <= irq;
   end

   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)                      pend[g] <= 1'b0;
         else if (irq[g] && !irq_prev[g]) pend[g] <= 1'b1;
         else if (clr[g])                 pend[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/intc_svc_reg.sv
module intc_svc_reg #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_oh,
   input  logic         retire,
   output logic [N-1:0] svc,
   output logic [N-1:0] allow
);
   localparam int W = (N > 1) ? $clog2(N) : 1;

   logic         top_found;
   logic [W-1:0] top_idx;
   logic [N-1:0] top_oh;

   intc_first_set #(.N(N)) u_top (
      .vec(svc), .found(top_found), .idx(top_idx), .onehot(top_oh)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) svc <= '0;
      else        svc <= (svc & ~(retire ? top_oh : '0)) | set_oh;
   end

   // allow[i]: no level at or above priority i is in service
   assign allow[0] = ~svc[0];
   for (genvar g = 1; g < N; g++) begin : g_allow
      assign allow[g] = allow[g-1] & ~svc[g];
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
   parameter int N_LVL  = 8,
   parameter int DATA_W = 8,
   localparam int LVL_W  = $clog2(N_LVL),
   localparam int BASE_W = DATA_W - LVL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_LVL-1:0]  irq_in,
   input  logic              ack,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              int_out,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe
);
   import intc_pkg::*;

   if (N_LVL < 2 || (1 << LVL_W) != N_LVL) begin : g_bad_lvl
      $error("N_LVL must be a power of two of at least 2");
   end
   if (BASE_W < 1 || N_LVL > DATA_W) begin : g_bad_w
      $error("DATA_W too narrow for N_LVL");
   end

   logic [N_LVL-1:0]  pend, svc, allow, mask_q, elig, win_oh, take_oh;
   logic [BASE_W-1:0] base_q;
   logic [LVL_W-1:0]  win_idx, lvl_q;
   logic              win_found, ack_phase, ack_first, ack_second, retire;

   assign ack_first  = ack && !ack_phase;
   assign ack_second = ack &&  ack_phase;
   assign retire     = cfg_we && (cfg_addr == CFG_EOI);
   assign take_oh    = ack_first ? win_oh : '0;

   intc_req_latch #(.N(N_LVL)) u_req (
      .clk(clk), .rst_n(rst_n), .irq(irq_in), .clr(take_oh), .pend(pend)
   );

   assign elig = pend & ~mask_q & allow;

   intc_first_set #(.N(N_LVL)) u_pick (
      .vec(elig), .found(win_found), .idx(win_idx), .onehot(win_oh)
   );

   intc_svc_reg #(.N(N_LVL)) u_svc (
      .clk(clk), .rst_n(rst_n), .set_oh(take_oh), .retire(retire),
      .svc(svc), .allow(allow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q    <= '0;
         base_q    <= '0;
         ack_phase <= 1'b0;
         lvl_q     <= '0;
      end else begin
         if (cfg_we && cfg_addr == CFG_MASK) mask_q <= cfg_wdata[N_LVL-1:0];
         if (cfg_we && cfg_addr == CFG_BASE) base_q <= cfg_wdata[DATA_W-1:LVL_W];
         if (ack) ack_phase <= ~ack_phase;
         if (ack_first) lvl_q <= win_found ? win_idx : '1;
      end
   end

   assign int_out  = |elig;
   assign data_oe  = ack_second;
   assign data_out = ack_second ? {base_q, lvl_q} : '0;
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int N_LVL = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack,
   input logic             cfg_we,
   input logic [1:0]       cfg_addr,
   input logic             int_out,
   input logic             data_oe,
   input logic             ack_phase,
   input logic [N_LVL-1:0] mask_q,
   input logic [N_LVL-1:0] pend,
   input logic [N_LVL-1:0] svc
);
   logic eoi_w;
   assign eoi_w = cfg_we && (cfg_addr == 2'd2);

   assert_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ack_phase && int_out && !eoi_w) |=>
         ($countones(svc) == $past($countones(svc)) + 1));

   assert_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_w && !ack && svc != '0) |=>
         ($countones(svc) + 1 == $past($countones(svc))));

   assert_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask_q) |-> !int_out);

   assert_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      int_out |-> (|(pend & ~mask_q)));

   assert_bus_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |=> !data_oe);

   assert_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !ack_phase) |=> ack_phase);
endmodule

bind prio_intc intc_chk #(.N_LVL(N_LVL)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .int_out(int_out), .data_oe(data_oe), .ack_phase(ack_phase),
   .mask_q(mask_q), .pend(pend), .svc(svc)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
   localparam int CLK_P = 10;
   localparam logic [4:0] BASE = 5'b10101;
   // {irq pattern, mask, expected int_out, expected level}
   localparam logic [19:0] VEC [8] = '{
      {8'h01, 8'h00, 1'b1, 3'd0},
      {8'h80, 8'h00, 1'b1, 3'd7},
      {8'h0C, 8'h00, 1'b1, 3'd2},
      {8'h0C, 8'h04, 1'b1, 3'd3},
      {8'hF0, 8'hF0, 1'b0, 3'd0},
      {8'hA0, 8'h20, 1'b1, 3'd7},
      {8'h66, 8'h00, 1'b1, 3'd1},
      {8'hFF, 8'h7F, 1'b1, 3'd7}
   };

   logic       clk = 1'b0, rst_n = 1'b0, ack = 1'b0, cfg_we = 1'b0;
   logic [7:0] irq_in = '0, cfg_wdata = '0, data_out;
   logic [1:0] cfg_addr = '0;
   logic       int_out, data_oe;
   int n_chk = 0, n_fail = 0;

   prio_intc dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack(ack), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .int_out(int_out),
      .data_out(data_out), .data_oe(data_oe)
   );

   always #(CLK_P/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc; @(negedge clk); endtask

   task automatic do_reset;
      rst_n = 1'b0; irq_in = '0; ack = 1'b0; cfg_we = 1'b0;
      cyc; cyc; rst_n = 1'b1;
   endtask

   task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cyc; cfg_we = 1'b0;
   endtask

   task automatic raise(input logic [7:0] p);
      irq_in = p; cyc; #1;
   endtask

   task automatic ack_seq(output logic int_mid, output logic oe1,
                          output logic [7:0] typ, output logic oe2);
      ack = 1'b1; #1 oe1 = data_oe; cyc;
      ack = 1'b0; #1 int_mid = int_out; cyc;
      ack = 1'b1; #1 typ = data_out; oe2 = data_oe; cyc;
      ack = 1'b0; #1;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic m, o1, o2;
      logic [7:0] t;
      // R12: reset state
      do_reset; #1;
      check("R12 int after reset", int_out, 0);
      check("R12 oe after reset", data_oe, 0);
      check("R9 data idle zero", data_out, 0);
      raise(8'h08);
      check("R12 mask clear after reset", int_out, 1);
      ack_seq(m, o1, t, o2);
      check("R12 base zero type", t, 8'h03);
      check("R9 oe low first strobe", o1, 0);
      check("R9 oe high second strobe", o2, 1);
      check("R9 oe low idle", data_oe, 0);

      // table walk: R4 R6 R2 R3
      for (int i = 0; i < 8; i++) begin
         do_reset;
         cfg_write(2'd1, {BASE, 3'b000});
         cfg_write(2'd0, VEC[i][11:4]);
         raise(VEC[i][19:12]);
         check($sformatf("R3 vec%0d int", i), int_out, VEC[i][3]);
         if (VEC[i][3]) begin
            ack_seq(m, o1, t, o2);
            check($sformatf("R4 R6 vec%0d type", i), t, {BASE, VEC[i][2:0]});
         end
      end

      // R2: unmask later
      do_reset;
      cfg_write(2'd0, 8'hFF);
      raise(8'h20);
      check("R2 masked", int_out, 0);
      cfg_write(2'd0, 8'h00); #1;
      check("R2 unmasked", int_out, 1);

      // R7 nesting, R5, R8, R1
      do_reset;
      raise(8'h10);
      ack_seq(m, o1, t, o2);
      check("R5 int drops after grant", m, 0);
      check("R6 type level4", t, 8'h04);
      raise(8'h50);
      check("R7 lower held off", int_out, 0);
      raise(8'h52);
      check("R7 higher nests", int_out, 1);
      ack_seq(m, o1, t, o2);
      check("R7 nested type", t, 8'h01);
      cfg_write(2'd2, 8'h00); #1;
      check("R8 retire level1 only", int_out, 0);
      cfg_write(2'd2, 8'h00); #1;
      check("R8 retire level4 frees 6", int_out, 1);
      ack_seq(m, o1, t, o2);
      check("R7 type level6", t, 8'h06);
      cfg_write(2'd2, 8'h00); #1;
      check("R1 held lines no relatch", int_out, 0);

      // R10 same-cycle edge and grant
      do_reset;
      raise(8'h04);
      raise(8'h00);
      ack = 1'b1; irq_in = 8'h04; cyc;
      ack = 1'b0; #1;
      check("R10 blocked while in service", int_out, 0);
      ack = 1'b1; cyc; ack = 1'b0;
      cfg_write(2'd2, 8'h00); #1;
      check("R10 fresh request kept", int_out, 1);
      ack_seq(m, o1, t, o2);
      check("R10 fresh request type", t, 8'h02);

      // R11 spurious grant
      do_reset;
      cfg_write(2'd1, {BASE, 3'b000});
      ack_seq(m, o1, t, o2);
      check("R11 spurious level7", t, {BASE, 3'd7});
      raise(8'h80);
      check("R11 no in-service set", int_out, 1);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule